// File: doc/BRIEF.md
# Framed List Serializer

This block turns a stream of list elements produced by hardware into a stream of fixed-width phits for a hardware receiver, where neither end can hold an entire list. Elements are gathered in a small on-chip buffer sized for one frame. A frame is sent when the buffer reaches its maximum size, when a list closes with elements still buffered, or when a nested list opens while elements of the outer list are still buffered. Each frame is one header phit followed by the buffered elements, oldest first.

The header carries the number of elements in the frame and the nesting depth of the list that owns it. Closing a list always produces a zero-count frame. From each header alone the receiver can tell whether data follows, whether a list has just finished, and at which depth. Lists may nest. The input beat type is chosen by two flags: a beat with the open flag starts a list, a beat with only the close flag ends one, and any other beat is an element.

Top module: `list_frame_ser`

## Requirements
- R1: After reset `phitValid` is 0, `elemReady` is 1, the buffer is empty and the nesting depth is 0.
- R2: A header is a single phit. The element count sits in bits 15:0, the nesting depth (1 for the outermost list) in bits 23:16, and every higher bit is zero.
- R3: When `MAX_FRAME` elements are buffered, a frame with count `MAX_FRAME` is sent, followed by those elements in arrival order. `elemReady` stays low from the moment the buffer fills until the last element phit of that frame is taken.
- R4: A close beat that arrives while k elements are buffered (0 < k < `MAX_FRAME`) first produces a frame with count k and those k elements, then the terminating frame.
- R5: Every accepted close beat at depth d > 0 produces a header with count 0 and depth d, after which the depth becomes d-1. A list with no elements produces only this header.
- R6: An open beat that arrives while elements are buffered first flushes them as a frame at the outer depth. Frames of the nested list carry depth+1, and frames after the nested list closes carry the outer depth again.
- R7: While `phitValid` is high and `phitReady` is low, `phitValid` stays high and `phitData` holds its value.
- R8: An element beat or close beat arriving at depth 0 is accepted and discarded, and it produces no phit.
- R9: No frame carries more than `MAX_FRAME` elements, and no element is written into a full buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| elemValid | input | 1 | Input beat valid |
| elemReady | output | 1 | Input beat accepted when high together with elemValid |
| elemOpen | input | 1 | Beat opens a list (data ignored, takes priority over elemClose) |
| elemClose | input | 1 | Beat closes the current list (data ignored) |
| elemData | input | DATA_W | Element value for element beats |
| phitValid | output | 1 | Output phit valid |
| phitReady | input | 1 | Receiver takes the phit when high together with phitValid |
| phitData | output | DATA_W | Header or element phit |

## Verification
On every cycle, assertions check that the output holds steady under backpressure, that nothing is written into a full buffer, that a data frame never has a zero count, that a terminating frame never appears at depth 0, and that a drained buffer is empty afterwards. The exact phit sequence can only be shown by the bench scenarios. Those scenarios cover the header layout, frames cut at the maximum size, partial frames at a close, the flush and depth changes around nested lists, and beats discarded outside any list. Each scenario compares the collected phits against a model built from the requirements.

// File: rtl/list_frame_pkg.sv
package list_frame_pkg;
  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic push;      // write elemData into the buffer
    logic pop;       // advance the drain pointer
    logic clear;     // empty the buffer after a frame
    logic levelUp;   // a list opened
    logic levelDown; // a list closed
    logic selHdr;    // drive a header with the buffered count
    logic selEmpty;  // drive a zero-count header
  } serStrobe_t;

  localparam int unsigned CountBits = 16;
  localparam int unsigned LevelBits = 8;
endpackage

// File: rtl/list_frame_dp.sv
module list_frame_dp
  import list_frame_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned MAX_FRAME = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  serStrobe_t        stb,
  input  logic [DATA_W-1:0] elemData,
  output logic [DATA_W-1:0] phitData,
  output logic              bufEmpty,
  output logic              bufFull,
  output logic              rdLast,
  output logic              levelZero
);
  localparam int unsigned CW = $clog2(MAX_FRAME + 1);
  localparam int unsigned AW = (MAX_FRAME > 1) ? $clog2(MAX_FRAME) : 1;

  logic [DATA_W-1:0]    mem [MAX_FRAME];
  logic [CW-1:0]        wrCnt;
  logic [CW-1:0]        rdPtr;
  logic [LevelBits-1:0] level;

  always_ff @(posedge clk) begin
    if (stb.push) mem[wrCnt[AW-1:0]] <= elemData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrCnt <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (stb.clear) begin
        wrCnt <= '0;
        rdPtr <= '0;
      end else begin
        if (stb.push) wrCnt <= wrCnt + 1'b1;
        if (stb.pop)  rdPtr <= rdPtr + 1'b1;
      end
      if (stb.levelUp)        level <= level + 1'b1;
      else if (stb.levelDown) level <= level - 1'b1;
    end
  end

  assign bufEmpty  = (wrCnt == '0);
  assign bufFull   = (wrCnt == CW'(MAX_FRAME));
  assign rdLast    = (rdPtr == wrCnt - 1'b1);
  assign levelZero = (level == '0);

  always_comb begin
    phitData = '0;
    if (stb.selHdr) begin
      phitData[CountBits-1:0]                   = CountBits'(wrCnt);
      phitData[CountBits+LevelBits-1:CountBits] = level;
    end else if (stb.selEmpty) begin
      phitData[CountBits+LevelBits-1:CountBits] = level;
    end else begin
      phitData = mem[rdPtr[AW-1:0]];
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.push |-> !bufFull);
  // R4
  no_empty_data_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.selHdr |-> !bufEmpty);
  // R8
  no_term_at_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.selEmpty |-> !levelZero);
  // R3
  drain_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pop && rdLast) |=> bufEmpty);
endmodule

// File: rtl/list_frame_ctrl.sv
module list_frame_ctrl
  import list_frame_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       elemValid,
  input  logic       elemOpen,
  input  logic       elemClose,
  output logic       elemReady,
  output logic       phitValid,
  input  logic       phitReady,
  input  logic       bufEmpty,
  input  logic       bufFull,
  input  logic       rdLast,
  input  logic       levelZero,
  output serStrobe_t stb
);
  typedef enum logic [1:0] {Collect, SendHdr, SendData, SendEmpty} state_t;
  state_t state, stateNext;

  logic needFlush;
  assign needFlush = elemValid && (elemOpen || elemClose) && !bufEmpty;

  always_comb begin
    stb       = '0;
    stateNext = state;
    elemReady = 1'b0;
    phitValid = 1'b0;
    unique case (state)
      Collect: begin
        if (bufFull || needFlush) begin
          stateNext = SendHdr;
        end else begin
          elemReady = 1'b1;
          if (elemValid) begin
            if (elemOpen) begin
              stb.levelUp = 1'b1;
            end else if (elemClose) begin
              if (!levelZero) stateNext = SendEmpty;
            end else begin
              stb.push = !levelZero;
            end
          end
        end
      end
      SendHdr: begin
        phitValid  = 1'b1;
        stb.selHdr = 1'b1;
        if (phitReady) stateNext = SendData;
      end
      SendData: begin
        phitValid = 1'b1;
        if (phitReady) begin
          stb.pop = 1'b1;
          if (rdLast) begin
            stb.clear = 1'b1;
            stateNext = Collect;
          end
        end
      end
      SendEmpty: begin
        phitValid    = 1'b1;
        stb.selEmpty = 1'b1;
        if (phitReady) begin
          stb.levelDown = 1'b1;
          stateNext     = Collect;
        end
      end
      default: stateNext = Collect;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= Collect;
    else       state <= stateNext;
  end

  // R6
  open_only_when_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (elemValid && elemReady && elemOpen) |=> !phitValid || $past(bufEmpty));
endmodule

// File: rtl/list_frame_ser.sv
module list_frame_ser
  import list_frame_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned MAX_FRAME = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              elemValid,
  output logic              elemReady,
  input  logic              elemOpen,
  input  logic              elemClose,
  input  logic [DATA_W-1:0] elemData,
  output logic              phitValid,
  input  logic              phitReady,
  output logic [DATA_W-1:0] phitData
);
  serStrobe_t stb;
  logic bufEmpty, bufFull, rdLast, levelZero;

  list_frame_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .elemValid(elemValid), .elemOpen(elemOpen), .elemClose(elemClose),
    .elemReady(elemReady), .phitValid(phitValid), .phitReady(phitReady),
    .bufEmpty(bufEmpty), .bufFull(bufFull), .rdLast(rdLast),
    .levelZero(levelZero), .stb(stb)
  );

  list_frame_dp #(.DATA_W(DATA_W), .MAX_FRAME(MAX_FRAME)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .elemData(elemData),
    .phitData(phitData), .bufEmpty(bufEmpty), .bufFull(bufFull),
    .rdLast(rdLast), .levelZero(levelZero)
  );

  // R7
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phitValid && !phitReady) |=> (phitValid && $stable(phitData)));
  // R3
  stall_input_while_drain_chk: assert property (@(posedge clk) disable iff (!rstN)
    phitValid |-> !elemReady);
endmodule

// File: tb/list_frame_ser_tb.sv
module list_frame_ser_tb_top;
  localparam int DW  = 32;
  localparam int MAX = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic elemValid = 1'b0, elemOpen = 1'b0, elemClose = 1'b0;
  logic [DW-1:0] elemData = '0;
  logic elemReady, phitValid;
  logic phitReady = 1'b1;
  logic [DW-1:0] phitData;

  always #2 clk = ~clk; // 250 MHz

  list_frame_ser #(.DATA_W(DW), .MAX_FRAME(MAX)) dut_i (
    .clk(clk), .rstN(rstN), .elemValid(elemValid), .elemReady(elemReady),
    .elemOpen(elemOpen), .elemClose(elemClose), .elemData(elemData),
    .phitValid(phitValid), .phitReady(phitReady), .phitData(phitData)
  );

  int checks = 0, fails = 0;
  int cyc = 0;
  bit throttle = 0;
  bit prevStall = 0;
  logic [DW-1:0] prevData = '0;
  int stallViol = 0, drainViol = 0, stallSeen = 0;

  logic [DW-1:0] got[$];
  logic [DW-1:0] exp[$];
  bit qOpen[$], qClose[$];
  logic [DW-1:0] qData[$];

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic logic [DW-1:0] hdr(input int cnt, input int lvl);
    logic [DW-1:0] h = '0;
    h[15:0]  = 16'(cnt);
    h[23:16] = 8'(lvl);
    return h;
  endfunction

  // output monitor: ready changes and sampling at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (prevStall) begin
        stallSeen++;
        if (!phitValid || phitData !== prevData) stallViol++;
      end
      if (phitValid && elemReady) drainViol++;
    end
    phitReady = throttle ? ((cyc % 3) != 0) : 1'b1;
    prevStall = rstN && phitValid && !phitReady;
    prevData  = phitData;
    if (rstN && phitValid && phitReady) got.push_back(phitData);
  end

  task automatic beat(input bit op, input bit cl, input logic [DW-1:0] d);
    qOpen.push_back(op); qClose.push_back(cl); qData.push_back(d);
  endtask

  // reference built from the requirements
  task automatic buildExpected();
    int lvl = 0;
    logic [DW-1:0] buff[$];
    exp.delete();
    foreach (qOpen[i]) begin
      if (qOpen[i]) begin
        if (buff.size() > 0) begin
          exp.push_back(hdr(buff.size(), lvl));
          foreach (buff[j]) exp.push_back(buff[j]);
          buff.delete();
        end
        lvl++;
      end else if (qClose[i]) begin
        if (lvl > 0) begin
          if (buff.size() > 0) begin
            exp.push_back(hdr(buff.size(), lvl));
            foreach (buff[j]) exp.push_back(buff[j]);
            buff.delete();
          end
          exp.push_back(hdr(0, lvl));
          lvl--;
        end
      end else if (lvl > 0) begin
        buff.push_back(qData[i]);
        if (buff.size() == MAX) begin
          exp.push_back(hdr(MAX, lvl));
          foreach (buff[j]) exp.push_back(buff[j]);
          buff.delete();
        end
      end
    end
  endtask

  task automatic runBeats(input string req);
    got.delete();
    stallViol = 0; drainViol = 0;
    buildExpected();
    foreach (qOpen[i]) begin
      @(negedge clk);
      elemValid = 1'b1; elemOpen = qOpen[i]; elemClose = qClose[i]; elemData = qData[i];
      #1;
      while (!elemReady) begin
        @(negedge clk);
        #1;
      end
      @(posedge clk);
    end
    @(negedge clk);
    elemValid = 1'b0; elemOpen = 1'b0; elemClose = 1'b0;
    repeat (60) @(negedge clk);
    check(got.size() == exp.size(), {req, " phit count"}, DW'(got.size()), DW'(exp.size()));
    foreach (exp[i])
      if (i < got.size()) check(got[i] === exp[i], {req, " phit"}, got[i], exp[i]);
    check(drainViol == 0, "R3 input stalled while draining", DW'(drainViol), 0);
    qOpen.delete(); qClose.delete(); qData.delete();
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(phitValid === 1'b0, "R1 phitValid after reset", DW'(phitValid), 0);
    check(elemReady === 1'b1, "R1 elemReady after reset", DW'(elemReady), 1);
  endtask

  task automatic t_emptyList();
    beat(1, 0, '0); beat(0, 1, '0);
    runBeats("R5 empty list");
    check(got.size() == 1 && got[0] === 32'h0001_0000, "R2 header layout",
          got.size() > 0 ? got[0] : '0, 32'h0001_0000);
  endtask

  task automatic t_exactFrame();
    beat(1, 0, '0);
    for (int i = 0; i < MAX; i++) beat(0, 0, 32'hA000_0000 + i);
    beat(0, 1, '0);
    runBeats("R9 exact frame");
    check(got.size() > 0 && got[0] === hdr(MAX, 1), "R3 full frame header",
          got.size() > 0 ? got[0] : '0, hdr(MAX, 1));
  endtask

  task automatic t_partial();
    beat(1, 0, '0);
    for (int i = 0; i < 3; i++) beat(0, 0, 32'hB000_0010 + i);
    beat(0, 1, '0);
    runBeats("R4 partial frame");
  endtask

  task automatic t_longThrottled();
    throttle = 1;
    stallSeen = 0;
    beat(1, 0, '0);
    for (int i = 0; i < 9; i++) beat(0, 0, 32'hC0DE_0000 + i);
    beat(0, 1, '0);
    runBeats("R3 long list");
    check(stallViol == 0, "R7 hold under stall", DW'(stallViol), 0);
    check(stallSeen > 0, "R7 stall exercised", DW'(stallSeen), 1);
    throttle = 0;
  endtask

  task automatic t_nested();
    beat(1, 0, '0); beat(0, 0, 32'h11); beat(0, 0, 32'h22);
    beat(1, 0, '0); beat(0, 0, 32'h33); beat(0, 1, '0);
    beat(0, 0, 32'h44); beat(0, 1, '0);
    runBeats("R6 nested");
    check(got.size() > 3 && got[3] === hdr(1, 2), "R6 nested depth",
          got.size() > 3 ? got[3] : '0, hdr(1, 2));
  endtask

  task automatic t_outside();
    beat(0, 0, 32'hDEAD); beat(0, 1, '0); beat(0, 0, 32'hBEEF);
    beat(1, 0, '0); beat(0, 1, '0);
    runBeats("R8 outside list");
    check(got.size() > 0 && got[0] === hdr(0, 1), "R8 first phit after discards",
          got.size() > 0 ? got[0] : '0, hdr(0, 1));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_emptyList();
    t_exactFrame();
    t_partial();
    t_longThrottled();
    t_nested();
    t_outside();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule